// File: doc/BRIEF.md
# Daisy-Chained Prioritized Interrupt Controller

This block is the interrupt logic of a two-channel serial peripheral that sits in a hardware priority daisy chain. Each channel has three interrupt sources: receive data ready, transmit buffer empty and external/status change. Each source has a pending flag and an in-service flag. The block drives an active-low interrupt request, passes priority down the chain through its enable-out pin, and answers an acknowledge read by marking the winning source as in service and returning a vector.

Software programs the block through a small register port. Each register access is qualified by a channel select. The command register accepts a "release highest in-service" code and a "clear external/status pending" code. A per-channel enable register, a shared master enable and a shared vector register complete the set. Systems that never run acknowledge cycles can poll a status register and clear the pending flags directly. The request line then simply follows the pending flags.

Top module: `dchain_irq_ctrl`

## Requirements
- R1: While `rst` is high, and at the first sample after it, every pending and in-service flag is clear, `int_n` is 1, `rd_data` is 0, the master enable is 0 and all source enables are 0.
- R2: `int_n` is 0 in the cycle after one in which all of these hold: `iei` is 1, `ack_cycle` is 0, the master enable (address 9, bit 0) is 1, and some source has its enable bit (address 1 of its channel: bit 0 receive, bit 1 transmit, bit 2 ext/status) set, its pending flag set and no in-service flag set at its own or any higher priority. In every other case `int_n` is 1 in that cycle.
- R3: Without acknowledge cycles, `int_n` stays low for as long as the pending flag stays set. A read of address 3 returns that channel's pending flags in bits [2:0] (bit 0 receive, bit 1 transmit, bit 2 ext/status), with the read data registered one cycle after `rd_en`.
- R4: A write to address 8 clears the transmit pending flag of the selected channel. A read of address 8 with `ack_cycle` low clears its receive pending flag. Writing 0x10 to address 0 clears its ext/status pending flag. A source event in the same cycle as a clear leaves the flag set.
- R5: A read with `ack_cycle` and `iei` high, while a request exists, sets the in-service flag of the highest-priority requesting source. The priority order runs from index 0 (highest) to index 5: channel A receive, channel A transmit, channel A ext/status, channel B receive, channel B transmit, channel B ext/status. The next `rd_data` is the vector with bits [3:1] replaced by that index.
- R6: Writing 0x38 to address 0 clears only the highest-priority in-service flag that is set.
- R7: While an in-service flag is set, sources of equal or lower priority raise no request, and a pending source of higher priority does raise one, so service nests.
- R8: The vector register (address 2) is shared by both channels. Reading it on channel A (`rd_chan`=0) returns the stored value. Reading it on channel B returns the value with bits [3:1] set to the index of the highest-priority requesting source, or 7 if there is none.
- R9: `ieo` is 1 exactly when `iei` is 1, no in-service flag is set, and it is not the case that `ack_cycle` is 1 while any pending flag is set.
- R10: With `iei` low, `int_n` stays 1, and an acknowledge read sets no in-service flag and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iei | input | 1 | Chain enable from the upstream device |
| ieo | output | 1 | Chain enable to the downstream device |
| int_n | output | 1 | Active-low interrupt request, registered |
| ack_cycle | input | 1 | High while an interrupt acknowledge cycle runs |
| rd_en | input | 1 | Read strobe (an acknowledge read when `ack_cycle` is high) |
| rd_chan | input | CHW | Channel select for reads |
| rd_addr | input | AW | Read register address |
| rd_data | output | DW | Registered read data, 0 when no read |
| wr_en | input | 1 | Write strobe |
| wr_chan | input | CHW | Channel select for writes |
| wr_addr | input | AW | Write register address |
| wr_data | input | DW | Write data |
| ev_rx_full | input | NCH | Per-channel receive-ready event |
| ev_tx_empty | input | NCH | Per-channel transmit-empty event |
| ev_ext | input | NCH | Per-channel external/status event |

## Verification
The hardest state to reach is two nested in-service levels with a still lower-priority source pending underneath them. The release command then has to peel off exactly the top level and reopen only the sources between the two levels. The directed part builds this on purpose. It acknowledges a channel B receive, raises a channel A receive, acknowledges that as well, and then issues the release command twice with pending flags still set. Random traffic follows, with acknowledge reads, release commands and source events close together, so that acknowledges collide with releases and events land on the same cycle as clears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPES  = 3;
  localparam int TY_RX  = 0;
  localparam int TY_TX  = 1;
  localparam int TY_EXT = 2;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest index wins: one-hot grant of the highest-priority set bit.
module irq_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_onehot_enc.sv
module irq_onehot_enc #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [N-1:0] oh,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) idx = idx | W'(i);
    end
  end
endmodule

// File: rtl/irq_cell.sv
// Pending and in-service flags of one source. Set wins over clear.
module irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic ip_set,
  input  logic ip_clr,
  input  logic ius_set,
  input  logic ius_clr,
  output logic ip,
  output logic ius
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= 1'b0;
      ius <= 1'b0;
    end else begin
      ip  <= ip_set  | (ip  & ~ip_clr);
      ius <= ius_set | (ius & ~ius_clr);
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
// Writable configuration and command decode.
module irq_cfg_regs #(
  parameter int NCH         = 2,
  parameter int CHW         = 1,
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int ADDR_CMD    = 0,
  parameter int ADDR_EN     = 1,
  parameter int ADDR_VEC    = 2,
  parameter int ADDR_DATA   = 8,
  parameter int ADDR_MIE    = 9,
  parameter int CMD_RST_IUS = 'h38,
  parameter int CMD_RST_EXT = 'h10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [CHW-1:0]                   wr_chan,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [DW-1:0]                    wr_data,
  output logic                             mie,
  output logic [NCH*irq_pkg::TYPES-1:0]    src_en,
  output logic [DW-1:0]                    vec_reg,
  output logic [NCH-1:0]                   clr_tx,
  output logic [NCH-1:0]                   clr_ext,
  output logic                             rst_ius_hi
);
  import irq_pkg::*;

  logic is_cmd, is_data;
  assign is_cmd  = wr_en && (wr_addr == AW'(ADDR_CMD));
  assign is_data = wr_en && (wr_addr == AW'(ADDR_DATA));
  assign rst_ius_hi = is_cmd && (wr_data == DW'(CMD_RST_IUS));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic sel;
    assign sel         = (wr_chan == CHW'(ch));
    assign clr_tx[ch]  = is_data && sel;
    assign clr_ext[ch] = is_cmd && sel && (wr_data == DW'(CMD_RST_EXT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mie     <= 1'b0;
      src_en  <= '0;
      vec_reg <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_MIE)) mie <= wr_data[0];
      if (wr_addr == AW'(ADDR_VEC)) vec_reg <= wr_data;
      if (wr_addr == AW'(ADDR_EN))
        src_en[int'(wr_chan)*TYPES +: TYPES] <= wr_data[TYPES-1:0];
    end
  end
endmodule

// File: rtl/dchain_irq_ctrl.sv
module dchain_irq_ctrl #(
  parameter int NCH         = 2,
  parameter int CHW         = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int ADDR_CMD    = 0,
  parameter int ADDR_EN     = 1,
  parameter int ADDR_VEC    = 2,
  parameter int ADDR_STAT   = 3,
  parameter int ADDR_DATA   = 8,
  parameter int ADDR_MIE    = 9,
  parameter int CMD_RST_IUS = 'h38,
  parameter int CMD_RST_EXT = 'h10,
  parameter int CODE_LSB    = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iei,
  output logic           ieo,
  output logic           int_n,
  input  logic           ack_cycle,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_chan,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] ev_rx_full,
  input  logic [NCH-1:0] ev_tx_empty,
  input  logic [NCH-1:0] ev_ext
);
  import irq_pkg::*;

  localparam int NSRC = NCH * TYPES;
  localparam int IW   = $clog2(NSRC + 1);

  logic            mie, rst_ius_hi;
  logic [NSRC-1:0] src_en, ip, ius, ip_set, ip_clr, ius_set, ius_clr;
  logic [NSRC-1:0] ius_pfx, req, req_grant, ius_grant;
  logic [DW-1:0]   vec_reg, vec_coded;
  logic [NCH-1:0]  clr_tx, clr_ext;
  logic [IW-1:0]   req_idx, code;
  logic            req_any, ack_take, rx_read;

  irq_cfg_regs #(
    .NCH(NCH), .CHW(CHW), .DW(DW), .AW(AW),
    .ADDR_CMD(ADDR_CMD), .ADDR_EN(ADDR_EN), .ADDR_VEC(ADDR_VEC),
    .ADDR_DATA(ADDR_DATA), .ADDR_MIE(ADDR_MIE),
    .CMD_RST_IUS(CMD_RST_IUS), .CMD_RST_EXT(CMD_RST_EXT)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_addr(wr_addr), .wr_data(wr_data), .mie(mie), .src_en(src_en),
    .vec_reg(vec_reg), .clr_tx(clr_tx), .clr_ext(clr_ext),
    .rst_ius_hi(rst_ius_hi)
  );

  assign rx_read = rd_en && !ack_cycle && (rd_addr == AW'(ADDR_DATA));

  // Map per-channel events and clears onto the flat priority index.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_map
    assign ip_set[ch*TYPES+TY_RX]  = ev_rx_full[ch];
    assign ip_set[ch*TYPES+TY_TX]  = ev_tx_empty[ch];
    assign ip_set[ch*TYPES+TY_EXT] = ev_ext[ch];
    assign ip_clr[ch*TYPES+TY_RX]  = rx_read && (rd_chan == CHW'(ch));
    assign ip_clr[ch*TYPES+TY_TX]  = clr_tx[ch];
    assign ip_clr[ch*TYPES+TY_EXT] = clr_ext[ch];
  end

  // Internal chain: in-service at this or a higher priority blocks a source.
  assign ius_pfx[0] = ius[0];
  for (genvar i = 1; i < NSRC; i++) begin : g_pfx
    assign ius_pfx[i] = ius_pfx[i-1] | ius[i];
  end

  assign req     = {NSRC{mie}} & src_en & ip & ~ius_pfx;
  assign req_any = |req;

  irq_prio_pick #(.N(NSRC)) u_req_pick (.req(req), .grant(req_grant));
  irq_prio_pick #(.N(NSRC)) u_ius_pick (.req(ius), .grant(ius_grant));
  irq_onehot_enc #(.N(NSRC), .W(IW)) u_enc (.oh(req_grant), .idx(req_idx));

  assign ack_take = rd_en && ack_cycle && iei && req_any;
  assign ius_set  = {NSRC{ack_take}} & req_grant;
  assign ius_clr  = {NSRC{rst_ius_hi}} & ius_grant;

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    irq_cell u_cell (
      .clk(clk), .rst(rst), .ip_set(ip_set[i]), .ip_clr(ip_clr[i]),
      .ius_set(ius_set[i]), .ius_clr(ius_clr[i]), .ip(ip[i]), .ius(ius[i])
    );
  end

  assign code = req_any ? req_idx : '1;
  always_comb begin
    vec_coded = vec_reg;
    vec_coded[CODE_LSB +: IW] = code;
  end

  // External chain output.
  assign ieo = iei && !(|ius) && !(ack_cycle && |ip);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n   <= 1'b1;
      rd_data <= '0;
    end else begin
      int_n <= !(iei && !ack_cycle && req_any);
      if (!rd_en) begin
        rd_data <= '0;
      end else if (ack_cycle) begin
        rd_data <= ack_take ? vec_coded : '0;
      end else if (rd_addr == AW'(ADDR_VEC)) begin
        rd_data <= (rd_chan == '0) ? vec_reg : vec_coded;
      end else if (rd_addr == AW'(ADDR_STAT)) begin
        rd_data <= DW'(ip[int'(rd_chan)*TYPES +: TYPES]);
      end else begin
        rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
  parameter int NSRC = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            iei,
  input logic            ieo,
  input logic            int_n,
  input logic            ack_cycle,
  input logic            rd_en,
  input logic            mie,
  input logic            rst_ius_hi,
  input logic            req_any,
  input logic [NSRC-1:0] ip,
  input logic [NSRC-1:0] ius
);
  logic take;
  assign take = rd_en && ack_cycle && iei && req_any;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ip == '0 && ius == '0 && int_n));

  // R2
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> $past(iei && !ack_cycle && mie));

  // R5
  ack_sets_one_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !rst_ius_hi) |=> $countones(ius) == $past($countones(ius)) + 1);

  // R5
  new_ius_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ius & ~$past(ius)));

  // R6
  release_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_ius_hi && !take) |=> ius == ($past(ius) & ($past(ius) - 1'b1)));

  // R9
  ieo_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ieo |-> (iei && ius == '0));

  // R10
  iei_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !iei |=> int_n);
endmodule

bind dchain_irq_ctrl irq_chk #(.NSRC(NSRC)) u_irq_chk (
  .clk(clk), .rst(rst), .iei(iei), .ieo(ieo), .int_n(int_n),
  .ack_cycle(ack_cycle), .rd_en(rd_en), .mie(mie),
  .rst_ius_hi(rst_ius_hi), .req_any(req_any), .ip(ip), .ius(ius)
);

// File: tb/dchain_irq_ctrl_bench.sv
module dchain_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       iei = 1'b1, ack_cycle = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [0:0] rd_chan = '0, wr_chan = '0;
  logic [3:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] ev_rx_full = '0, ev_tx_empty = '0, ev_ext = '0;
  logic       ieo, int_n;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference state
  logic [5:0] m_ip = '0, m_ius = '0, m_en = '0;
  logic       m_mie = 1'b0;
  logic [7:0] m_vec = '0, e_rd = '0;
  logic       e_int_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_irq_ctrl u_dchain_irq_ctrl (
    .clk(clk), .rst(rst), .iei(iei), .ieo(ieo), .int_n(int_n),
    .ack_cycle(ack_cycle), .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_rx_full(ev_rx_full), .ev_tx_empty(ev_tx_empty), .ev_ext(ev_ext)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] req_of(input logic [5:0] ip, ius, en, input logic mie);
    logic [5:0] r;
    for (int i = 0; i < 6; i++)
      r[i] = mie && en[i] && ip[i] && ((ius & 6'((1 << (i + 1)) - 1)) == '0);
    return r;
  endfunction

  function automatic logic [2:0] top_of(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 3'(i);
    return 3'd7;
  endfunction

  function automatic logic [7:0] coded(input logic [7:0] v, input logic [2:0] c);
    logic [7:0] r;
    r = v;
    r[3:1] = c;
    return r;
  endfunction

  // One clock: predict from current inputs, advance, compare at negedge.
  task automatic step();
    logic [5:0] rq, clr, setv, nius;
    logic [2:0] w;
    logic take;
    rq = req_of(m_ip, m_ius, m_en, m_mie);
    w = top_of(rq);
    take = rd_en && ack_cycle && iei && (rq != 0);
    e_int_n = !(iei && !ack_cycle && (rq != 0));
    if (!rd_en) e_rd = 8'h00;
    else if (ack_cycle) e_rd = take ? coded(m_vec, w) : 8'h00;
    else if (rd_addr == 4'd2) e_rd = rd_chan ? coded(m_vec, w) : m_vec;
    else if (rd_addr == 4'd3) e_rd = {5'b0, (rd_chan ? m_ip[5:3] : m_ip[2:0])};
    else e_rd = 8'h00;
    nius = m_ius;
    if (wr_en && wr_addr == 4'd0 && wr_data == 8'h38) nius = m_ius & (m_ius - 6'd1);
    if (take) nius[w] = 1'b1;
    clr = '0;
    if (wr_en && wr_addr == 4'd8) clr[wr_chan*3+1] = 1'b1;
    if (wr_en && wr_addr == 4'd0 && wr_data == 8'h10) clr[wr_chan*3+2] = 1'b1;
    if (rd_en && !ack_cycle && rd_addr == 4'd8) clr[rd_chan*3+0] = 1'b1;
    setv = {ev_ext[1], ev_tx_empty[1], ev_rx_full[1], ev_ext[0], ev_tx_empty[0], ev_rx_full[0]};
    @(posedge clk);
    m_ip = (m_ip & ~clr) | setv;
    m_ius = nius;
    if (wr_en && wr_addr == 4'd9) m_mie = wr_data[0];
    if (wr_en && wr_addr == 4'd2) m_vec = wr_data;
    if (wr_en && wr_addr == 4'd1) begin
      if (wr_chan) m_en[5:3] = wr_data[2:0]; else m_en[2:0] = wr_data[2:0];
    end
    @(negedge clk);
    chk({cur_req, " int_n"}, {7'b0, int_n}, {7'b0, e_int_n});
    chk({cur_req, " rd_data"}, rd_data, e_rd);
    chk({cur_req, " ieo"}, {7'b0, ieo},
        {7'b0, iei && (m_ius == 0) && !(ack_cycle && (m_ip != 0))});
    rd_en = 1'b0; wr_en = 1'b0;
    ev_rx_full = '0; ev_tx_empty = '0; ev_ext = '0;
  endtask

  task automatic wr(input logic ch, input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_chan = ch; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(input logic ch, input logic [3:0] a);
    rd_en = 1'b1; rd_chan = ch; rd_addr = a; step();
  endtask

  task automatic raise(input int idx);
    case (idx % 3)
      0: ev_rx_full[idx/3] = 1'b1;
      1: ev_tx_empty[idx/3] = 1'b1;
      default: ev_ext[idx/3] = 1'b1;
    endcase
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk("R1 int_n after reset", {7'b0, int_n}, 8'h01);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    idle(2);
    raise(1);                       // enables still off: no request
    idle(2);

    cur_req = "R2";
    wr(0, 4'd9, 8'h01);
    wr(0, 4'd1, 8'h07);
    wr(1, 4'd1, 8'h07);
    idle(2);
    chk("R2 A tx pending raises request", {7'b0, int_n}, 8'h00);

    cur_req = "R3";
    idle(3);
    rd(0, 4'd3);
    chk("R3 status shows A tx", rd_data, 8'h02);
    cur_req = "R4";
    wr(0, 4'd8, 8'h55);             // clears A tx
    idle(2);
    chk("R4 tx clear drops request", {7'b0, int_n}, 8'h01);
    raise(5);
    wr(1, 4'd0, 8'h10);             // clears B ext
    raise(0);
    rd(0, 4'd8);                    // clears A rx
    ev_tx_empty[1] = 1'b1; wr_en = 1'b1; wr_chan = 1'b1; wr_addr = 4'd8; wr_data = 8'h00;
    step();                         // set wins over clear
    rd(1, 4'd3);
    chk("R4 set wins over clear", rd_data, 8'h02);
    wr(1, 4'd8, 8'h00);
    idle(2);

    cur_req = "R5";
    wr(1, 4'd2, 8'hA0);
    raise(3);                       // B rx
    idle(1);
    ack_cycle = 1'b1;
    rd(0, 4'd0);
    chk("R5 ack vector for B rx", rd_data, 8'hA6);
    ack_cycle = 1'b0;
    idle(1);
    cur_req = "R7";
    raise(4);                       // B tx blocked by B rx in service
    idle(2);
    chk("R7 lower source blocked", {7'b0, int_n}, 8'h01);
    raise(0);                       // A rx nests
    idle(1);
    chk("R7 higher source nests", {7'b0, int_n}, 8'h00);
    ack_cycle = 1'b1;
    rd(0, 4'd0);
    chk("R7 nested ack vector", rd_data, 8'hA0);
    ack_cycle = 1'b0;
    cur_req = "R6";
    wr(0, 4'd0, 8'h38);             // releases A rx level only
    idle(2);
    chk("R6 A rx requests again", {7'b0, int_n}, 8'h00);
    rd(0, 4'd8);
    idle(2);
    chk("R6 B rx still in service", {7'b0, int_n}, 8'h01);
    wr(1, 4'd0, 8'h38);
    idle(2);
    chk("R6 second release reopens", {7'b0, int_n}, 8'h00);

    cur_req = "R8";
    rd(0, 4'd2);
    chk("R8 raw vector on A", rd_data, 8'hA0);
    rd(1, 4'd2);
    chk("R8 coded vector on B", rd_data, 8'hA6);

    cur_req = "R9";
    ack_cycle = 1'b1;
    step();
    chk("R9 ieo low while ack with pending", {7'b0, ieo}, 8'h00);
    ack_cycle = 1'b0;

    cur_req = "R10";
    iei = 1'b0;
    idle(2);
    chk("R10 no request with iei low", {7'b0, int_n}, 8'h01);
    ack_cycle = 1'b1;
    rd(0, 4'd0);
    chk("R10 ack ignored with iei low", rd_data, 8'h00);
    ack_cycle = 1'b0;
    iei = 1'b1;
    idle(2);
    chk("R10 nothing taken into service", {7'b0, int_n}, 8'h00);

    cur_req = "R2 random";
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom;
      iei = (r[3:0] != 0);
      ack_cycle = (r[7:4] < 2);
      ev_rx_full  = {r[8] & r[9] & r[22], r[10] & r[11] & r[23]};
      ev_tx_empty = {r[12] & r[13] & r[22], r[14] & r[15] & r[23]};
      ev_ext      = {r[16] & r[17] & r[24], r[18] & r[19] & r[25]};
      if (r[20]) begin
        rd_en = 1'b1; rd_chan = r[21];
        case (r[28:26] % 3) 0: rd_addr = 4'd2; 1: rd_addr = 4'd3; default: rd_addr = 4'd8; endcase
      end
      if (r[31:29] == 0) begin
        int unsigned q;
        q = $urandom;
        wr_en = 1'b1; wr_chan = q[0];
        case (q[3:1] % 6)
          0: begin wr_addr = 4'd0; wr_data = 8'h38; end
          1: begin wr_addr = 4'd0; wr_data = 8'h10; end
          2: begin wr_addr = 4'd8; wr_data = q[15:8]; end
          3: begin wr_addr = 4'd1; wr_data = (q[7:4] == 0) ? q[15:8] : 8'h07; end
          4: begin wr_addr = 4'd2; wr_data = q[15:8]; end
          default: begin wr_addr = 4'd9; wr_data = {7'b0, q[7:4] != 0}; end
        endcase
      end
      step();
    end
    ack_cycle = 1'b0;
    iei = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule